// File: doc/BRIEF.md
# Prescaled Edge-Aligned PWM Timer

This block produces one pulse-width-modulated output, for example to set the brightness of a lamp or LED. A programmable divider turns the input clock into a slower tick. An up-counter advances once per tick, runs from zero to a programmable top value and then returns to zero. A compare value sets how many ticks at the start of each period keep the output high. A one-clock update pulse marks every return to zero.

Three configuration values (divider, top and compare) are loaded through one write strobe with a select field. Each is stored as a count minus one where that applies: the tick rate is the clock rate divided by (divider + 1), and a period lasts (top + 1) ticks. While the timer runs, written values wait in a staging copy and only take effect at the next wrap, so no period is cut short or mixed. While the timer is disabled, written values take effect at once.

Top module: `pwm_tick_timer`

## Requirements
- R1: With divider value P, the counter advances once every P+1 clock cycles while enabled.
- R2: With top value T, one PWM period lasts (T+1) ticks, so update pulses are (T+1)*(P+1) clock cycles apart.
- R3: The counter counts upward only, from 0 to T, then back to 0.
- R4: With compare value C not greater than T, the output is high for the first C ticks of every period and low for the rest, i.e. C*(P+1) high clock cycles per period.
- R5: A compare value of 0 keeps the output low for the whole period.
- R6: A compare value greater than T keeps the output high for the whole period.
- R7: With T = 65535 and C = 65535 the output is high for 65535 of the 65536 ticks of a period and low for one.
- R8: The update pulse is one clock cycle wide, high in the first cycle in which the counter holds 0 after a wrap, and occurs once per period (whenever the period is longer than one clock).
- R9: While enabled, a written value takes effect at the next wrap: the period in progress keeps its old divider, top and compare values.
- R10: While the enable is low the counters stay at zero, the output is low and no update pulse is raised; after the enable rises the first update pulse comes (T+1)*(P+1) cycles later.
- R11: The select field encodes 0 = divider, 1 = top, 2 = compare; select 3 writes nothing.
- R12: After reset the output and the update pulse are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Run enable |
| wr_en | input | 1 | Write strobe for one configuration value |
| wr_sel | input | 2 | Which value is written (0 divider, 1 top, 2 compare) |
| wr_data | input | CNT_W (16) | Value to write |
| pwm_o | output | 1 | PWM output, registered |
| upd_o | output | 1 | Update pulse at each wrap |

## Verification
The output is registered from the counter value, so it trails the counter by one clock; a wrap at a clock edge shows on the update pulse right after that edge, and the output of the new period's first tick appears one clock later. The bench therefore aligns to an observed update pulse and then samples exactly (T+1)*(P+1) cycles, counting high samples and update pulses in that window, which covers precisely one period. Staged writes are issued inside a window and checked against the window that follows, and the restart after enable counts cycles from the enable edge to the first update pulse.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

   typedef enum logic [1:0] {
      CFG_DIV  = 2'd0,
      CFG_TOP  = 2'd1,
      CFG_CMP  = 2'd2,
      CFG_NONE = 2'd3
   } cfg_sel_e;

   localparam int NUM_CFG = 3;

endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow
   import pwm_tick_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] div_act,
   output logic [CNT_W-1:0] top_act,
   output logic [CNT_W-1:0] cmp_act
);

   logic [CNT_W-1:0] stage_q [NUM_CFG];
   logic [CNT_W-1:0] stage_d [NUM_CFG];
   logic [CNT_W-1:0] live_q  [NUM_CFG];

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
      logic hit;
      assign hit        = wr_en && (wr_sel == 2'(i));
      assign stage_d[i] = hit ? wr_data : stage_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[i] <= '0;
         end else begin
            stage_q[i] <= stage_d[i];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q[i] <= '0;
         end else if (!en || load) begin
            live_q[i] <= stage_d[i];
         end
      end

      assert_live_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         (en && !load) |=> $stable(live_q[i]));
   end

   assign div_act = live_q[CFG_DIV];
   assign top_act = live_q[CFG_TOP];
   assign cmp_act = live_q[CFG_CMP];

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] div_m1,
   output logic             tick
);

   logic [CNT_W-1:0] pcnt_q;
   logic             at_end;

   assign at_end = (pcnt_q >= div_m1);
   assign tick   = en && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (!en || at_end) begin
         pcnt_q <= '0;
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
      end
   end

   assert_div_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (pcnt_q <= div_m1));

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic at_top;

   assign at_top = (cnt >= top);
   assign wrap   = tick && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en || wrap) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_cnt_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= top));

   assert_wrap_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wrap,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   output logic             pwm_o,
   output logic             upd_o
);

   logic below;

   assign below = (cnt < cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_o <= 1'b0;
         upd_o <= 1'b0;
      end else begin
         pwm_o <= en && below;
         upd_o <= wrap;
      end
   end

endmodule

// File: rtl/pwm_tick_timer.sv
module pwm_tick_timer
   import pwm_tick_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_o,
   output logic             upd_o
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pwm_tick_timer: CNT_W must lie in 2..32");
   end

   logic [CNT_W-1:0] div_act;
   logic [CNT_W-1:0] top_act;
   logic [CNT_W-1:0] cmp_act;
   logic [CNT_W-1:0] cnt;
   logic             tick;
   logic             wrap;

   pwm_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .load    (wrap),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .div_act (div_act),
      .top_act (top_act),
      .cmp_act (cmp_act)
   );

   pwm_prescaler #(.CNT_W(CNT_W)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .div_m1 (div_act),
      .tick   (tick)
   );

   pwm_period_counter #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .tick  (tick),
      .top   (top_act),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   pwm_compare_out #(.CNT_W(CNT_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .wrap  (wrap),
      .cnt   (cnt),
      .cmp   (cmp_act),
      .pwm_o (pwm_o),
      .upd_o (upd_o)
   );

   assert_hold_between_ticks_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt));

   assert_zero_duty_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmp_act == '0) |=> !pwm_o);

   assert_full_duty_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmp_act > top_act) |=> pwm_o);

   assert_upd_at_zero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && en) |-> (cnt == '0));

   assert_disabled_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm_o && !upd_o && cnt == '0));

endmodule

// File: tb/pwm_tick_timer_bench.sv
module pwm_tick_timer_bench;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic         pwm_o;
   logic         upd_o;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   pwm_tick_timer #(.CNT_W(W)) u_pwm_tick_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .pwm_o   (pwm_o),
      .upd_o   (upd_o)
   );

   // {divider, top, compare}
   localparam logic [47:0] VEC [7] = '{
      {16'd0, 16'd9,  16'd3},
      {16'd1, 16'd4,  16'd2},
      {16'd2, 16'd7,  16'd5},
      {16'd3, 16'd5,  16'd5},
      {16'd0, 16'd15, 16'd15},
      {16'd4, 16'd2,  16'd1},
      {16'd0, 16'd1,  16'd1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input int val);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = W'(val);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_upd(input int lim, output bit ok);
      ok = 1'b0;
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (upd_o) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic measure(input int n, output int hi, output int ups, output bit last_up);
      hi = 0;
      ups = 0;
      last_up = 1'b0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (pwm_o) hi++;
         if (upd_o) ups++;
         if (k == n) last_up = upd_o;
      end
   endtask

   function automatic int exp_high(input int d, input int t, input int c);
      return (c > t) ? (t + 1) * (d + 1) : c * (d + 1);
   endfunction

   task automatic run_vec(input int d, input int t, input int c, input string tag);
      int  n, hi, ups;
      bit  ok, lu;
      n = (t + 1) * (d + 1);
      @(negedge clk);
      en = 1'b0;
      wr(2'd0, d);
      wr(2'd1, t);
      wr(2'd2, c);
      @(negedge clk);
      en = 1'b1;
      wait_upd(n + 8, ok);
      check(ok, {tag, " R10 first update"}, int'(ok), 1);
      measure(n, hi, ups, lu);
      check(hi == exp_high(d, t, c), {tag, " high cycles"}, hi, exp_high(d, t, c));
      check(ups == 1 && lu, {tag, " R2 R8 one update at period end"}, ups, 1);
   endtask

   initial begin
      #(4 * 190000);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int  hi, ups, cyc;
      bit  ok, lu;

      repeat (3) @(negedge clk);
      // R12: reset state
      check(pwm_o == 1'b0, "R12 pwm after reset", int'(pwm_o), 0);
      check(upd_o == 1'b0, "R12 upd after reset", int'(upd_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pwm_o == 1'b0 && upd_o == 1'b0, "R12 idle after reset", int'(pwm_o), 0);

      // table walk: R1 R2 R3 R4
      foreach (VEC[i]) begin
         run_vec(int'(VEC[i][47:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]), "R1 R2 R3 R4 table");
      end

      // R5: compare zero
      run_vec(1, 6, 0, "R5 zero duty");
      // R6: compare above top
      run_vec(2, 3, 9, "R6 full duty");
      run_vec(0, 0, 1, "R6 top zero");

      // R11: select 3 writes nothing
      @(negedge clk);
      en = 1'b0;
      wr(2'd0, 0);
      wr(2'd1, 3);
      wr(2'd2, 2);
      wr(2'd3, 16'hFFFF);
      @(negedge clk);
      en = 1'b1;
      wait_upd(12, ok);
      measure(4, hi, ups, lu);
      check(hi == 2 && ups == 1 && lu, "R11 select 3 ignored", hi, 2);

      // R9: staged writes wait for the wrap
      @(negedge clk);
      en = 1'b0;
      wr(2'd0, 0);
      wr(2'd1, 9);
      wr(2'd2, 3);
      @(negedge clk);
      en = 1'b1;
      wait_upd(20, ok);
      fork
         measure(10, hi, ups, lu);
         begin
            repeat (2) @(negedge clk);
            wr(2'd2, 7);
         end
      join
      check(hi == 3 && lu, "R9 old compare kept in current period", hi, 3);
      fork
         measure(10, hi, ups, lu);
         begin
            repeat (3) @(negedge clk);
            wr(2'd1, 4);
         end
      join
      check(hi == 7 && lu, "R9 new compare from next period", hi, 7);
      measure(5, hi, ups, lu);
      check(ups == 1 && lu, "R9 new top from next period", ups, 1);
      check(hi == 5, "R6 R9 compare above new top", hi, 5);

      // R10: disable and restart
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      hi = 0;
      ups = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (pwm_o) hi++;
         if (upd_o) ups++;
      end
      check(hi == 0 && ups == 0, "R10 quiet while disabled", hi + ups, 0);
      wr(2'd0, 1);
      wr(2'd1, 4);
      wr(2'd2, 2);
      @(negedge clk);
      en = 1'b1;
      cyc = 0;
      for (int k = 1; k <= 30; k++) begin
         @(negedge clk);
         if (upd_o) begin
            cyc = k;
            break;
         end
      end
      check(cyc == 10, "R10 restart from zero", cyc, 10);

      // R7: largest top and compare
      run_vec(0, 65535, 65535, "R7 max top");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule